// File: doc/BRIEF.md
# Wide-Range Counter-Based Frequency and Phase Detector

This block compares a supply-powered ring oscillator with a reference clock by counting oscillator rising edges in every reference period. A Gray-coded counter runs in the oscillator domain and is brought into the reference domain through a two-flop synchronizer. Each reference edge subtracts the previous captured count from the current one, and then subtracts the programmable target ratio `div_n`. The result is a signed frequency error for every reference period.

The frequency errors are summed into a phase accumulator, measured in oscillator cycles. Because it is a running sum of whole-cycle counts, it does not wrap at one oscillator cycle. It saturates at ±`PH_LIM` cycles. Every tenth accepted measurement produces a phase report, which gives the slow phase path of a two-rate control loop that sets a regulator duty code. Clearing `phase_en` gives frequency-only operation.

Both results leave on valid/ready streams. A measurement is never stalled. While `ready` is low, the held result stays valid. If a newer result arrives during that time, it replaces the held one, so the consumer always sees the latest value and no result is queued.

Top module: `wide_freq_phase_det`

## Requirements
- R1: While `rst_n` is low, `fe_valid` and `pe_valid` are 0. After the internal reference reset releases, the first three reference edges produce no measurement.
- R2: Once warm-up is over, each reference period gives one measurement. `fe_data` = (number of oscillator rising edges in that period) − `div_n`, as a two's-complement value of `CNT_W+1` bits.
- R3: The phase accumulator is the running sum of accepted frequency errors. On every tenth accepted measurement since the last clear, `pe_valid` is raised and `pe_data` equals the accumulator including that measurement. A report does not reset the accumulator.
- R4: The accumulator and `pe_data` saturate at +`PH_LIM` and −`PH_LIM`. The default is 8 oscillator cycles.
- R5: When `div_n` differs from the value registered at the previous edge, two measurements are dropped: the one ending at that edge and the next one. The accumulator and the decimation count are also cleared.
- R6: While `phase_en` is 0, the accumulator and the decimation count are held at zero and no phase report is made. The frequency stream continues. After `phase_en` returns to 1, the first report comes after ten measurements and starts from zero.
- R7: The count crosses clock domains in Gray code, so successive values differ in at most one bit. Counts are exact for up to 2^(`CNT_W`−1) oscillator edges per period.
- R8: On each stream, a result stays valid while `ready` is low. Its data is stable unless a newer result arrives, and a newer result replaces it. A transfer happens on a clock edge where both valid and ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Ring oscillator clock being measured |
| ref_clk | input | 1 | Reference clock; sets the measurement period |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized into both domains |
| div_n | input | N_W | Target oscillator edges per reference period |
| phase_en | input | 1 | 1 enables the phase path, 0 gives frequency-only operation |
| fe_valid | output | 1 | Frequency error stream valid |
| fe_ready | input | 1 | Frequency error stream ready |
| fe_data | output | CNT_W+1 | Signed frequency error in oscillator cycles |
| pe_valid | output | 1 | Phase error stream valid |
| pe_ready | input | 1 | Phase error stream ready |
| pe_data | output | clog2(PH_LIM+1)+1 | Signed saturated phase error in oscillator cycles |

## Verification
The assertions assume four things about the inputs. The oscillator runs well faster than the reference. Oscillator reset release is complete before the first counted reference period. Fewer than 2^(`CNT_W`−1) edges fall in one period. `div_n` and `phase_en` are synchronous to the reference clock. The stimulus changes every input half a reference period away from the active edge. It uses oscillator periods that give 5, 10, 12.5 and 20 edges per period. It waits several reference cycles after each oscillator change before it changes `div_n`, so that measurements spanning the frequency change are not checked.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;
  // reference edges dropped after reset while the synchronizer and last-sample register fill
  localparam int unsigned SKIP_AFTER_RST = 3;
  localparam int unsigned DEF_DECIM      = 10;
  localparam int unsigned DEF_PH_LIM     = 8;
endpackage

// File: rtl/fpd_osc_counter.sv
`timescale 1ns/1ps
module fpd_osc_counter #(
  parameter int W = 8
) (
  input  logic         osc_clk,
  input  logic         arst_n,
  output logic [W-1:0] gray_o
);
  logic [1:0]   rs_q;
  logic         orst_n;
  logic [W-1:0] bin_q;
  logic [W-1:0] bin_n;

  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign orst_n = rs_q[1];

  assign bin_n = bin_q + 1'b1;

  always_ff @(posedge osc_clk or negedge orst_n) begin
    if (!orst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_n;
      gray_o <= bin_n ^ (bin_n >> 1);
    end
  end

  // R7: the crossing value never moves by more than one bit per oscillator edge
  p_gray_onebit_r7: assert property (@(posedge osc_clk) disable iff (!orst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/fpd_count_xfer.sv
`timescale 1ns/1ps
module fpd_count_xfer
  import fpd_pkg::*;
#(
  parameter int W     = 8,
  parameter int N_W   = 8,
  parameter int ERR_W = W + 1
) (
  input  logic                    ref_clk,
  input  logic                    rst_n,
  input  logic [W-1:0]            gray_i,
  input  logic [N_W-1:0]          div_n,
  output logic                    meas_v,
  output logic signed [ERR_W-1:0] meas_err,
  output logic                    n_chg
);
  logic [W-1:0]   g1_q, g2_q, prev_q, cur, delta;
  logic [N_W-1:0] n_q;
  logic [1:0]     skip_q, skip_n;

  always_comb begin
    for (int i = 0; i < W; i++) cur[i] = ^(g2_q >> i);
  end

  assign delta    = cur - prev_q;
  assign meas_err = ERR_W'(delta) - ERR_W'(n_q);
  assign n_chg    = (div_n != n_q);
  assign meas_v   = (skip_q == 2'd0) && !n_chg;

  always_comb begin
    if (n_chg)                skip_n = (skip_q > 2'd1) ? skip_q - 2'd1 : 2'd1;
    else if (skip_q != 2'd0)  skip_n = skip_q - 2'd1;
    else                      skip_n = 2'd0;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q   <= '0;
      g2_q   <= '0;
      prev_q <= '0;
      n_q    <= '0;
      skip_q <= 2'(SKIP_AFTER_RST);
    end else begin
      g1_q   <= gray_i;
      g2_q   <= g1_q;
      prev_q <= cur;
      n_q    <= div_n;
      skip_q <= skip_n;
    end
  end

  // R5: the interval following a ratio change is never reported
  p_discard_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    n_chg |=> !meas_v);
endmodule

// File: rtl/fpd_phase_path.sv
`timescale 1ns/1ps
module fpd_phase_path #(
  parameter int ERR_W  = 9,
  parameter int PH_LIM = 8,
  parameter int PH_W   = $clog2(PH_LIM + 1) + 1,
  parameter int DECIM  = 10
) (
  input  logic                    ref_clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    meas_v,
  input  logic signed [ERR_W-1:0] meas_err,
  output logic                    ph_v,
  output logic signed [PH_W-1:0]  ph_err
);
  localparam int SUM_W = ((ERR_W > PH_W) ? ERR_W : PH_W) + 1;
  localparam int DC_W  = $clog2(DECIM);
  localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(PH_LIM);
  localparam logic signed [SUM_W-1:0] LIM_M = -SUM_W'(PH_LIM);

  logic signed [PH_W-1:0]  acc_q, acc_n;
  logic signed [SUM_W-1:0] sum;
  logic [DC_W-1:0]         dcnt_q;
  logic                    last;

  always_comb begin
    sum = acc_q;
    sum = sum + meas_err;
    if (sum > LIM_P)      acc_n = PH_W'(PH_LIM);
    else if (sum < LIM_M) acc_n = -PH_W'(PH_LIM);
    else                  acc_n = sum[PH_W-1:0];
  end

  assign last   = (dcnt_q == DC_W'(DECIM - 1));
  assign ph_v   = meas_v && last && !clr;
  assign ph_err = acc_n;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dcnt_q <= '0;
    end else if (clr) begin
      acc_q  <= '0;
      dcnt_q <= '0;
    end else if (meas_v) begin
      acc_q  <= acc_n;
      dcnt_q <= last ? '0 : dcnt_q + 1'b1;
    end
  end

  // R4: accumulator stays inside the saturation window
  p_acc_bound_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (acc_q <= PH_W'(PH_LIM)) && (acc_q >= -PH_W'(PH_LIM)));
  // R6: a clear leaves accumulator and decimation at zero
  p_clear_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clr |=> (acc_q == '0) && (dcnt_q == '0));
  // R3: a report restarts the ten-measurement window
  p_wrap_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ph_v |=> (dcnt_q == '0));
endmodule

// File: rtl/fpd_stream_reg.sv
`timescale 1ns/1ps
module fpd_stream_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= in_v | (valid & ~ready);
      if (in_v) data <= in_d;
    end
  end

  // R8: an unaccepted result is not withdrawn
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid);
  // R8: held data moves only when a newer result arrives
  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !in_v |=> $stable(data));
endmodule

// File: rtl/wide_freq_phase_det.sv
`timescale 1ns/1ps
module wide_freq_phase_det
  import fpd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_W    = 8,
  parameter int PH_LIM = DEF_PH_LIM,
  parameter int DECIM  = DEF_DECIM,
  localparam int ERR_W = CNT_W + 1,
  localparam int PH_W  = $clog2(PH_LIM + 1) + 1
) (
  input  logic             osc_clk,
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [N_W-1:0]   div_n,
  input  logic             phase_en,
  output logic             fe_valid,
  input  logic             fe_ready,
  output logic [ERR_W-1:0] fe_data,
  output logic             pe_valid,
  input  logic             pe_ready,
  output logic [PH_W-1:0]  pe_data
);
  logic [1:0]              rs_q;
  logic                    rrst_n;
  logic [CNT_W-1:0]        gray;
  logic                    meas_v, n_chg, ph_v;
  logic signed [ERR_W-1:0] meas_err;
  logic signed [PH_W-1:0]  ph_err;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rrst_n = rs_q[1];

  fpd_osc_counter #(.W(CNT_W)) u_cnt (
    .osc_clk(osc_clk), .arst_n(rst_n), .gray_o(gray)
  );

  fpd_count_xfer #(.W(CNT_W), .N_W(N_W), .ERR_W(ERR_W)) u_xfer (
    .ref_clk(ref_clk), .rst_n(rrst_n), .gray_i(gray), .div_n(div_n),
    .meas_v(meas_v), .meas_err(meas_err), .n_chg(n_chg)
  );

  fpd_phase_path #(.ERR_W(ERR_W), .PH_LIM(PH_LIM), .PH_W(PH_W), .DECIM(DECIM)) u_phase (
    .ref_clk(ref_clk), .rst_n(rrst_n), .clr(n_chg | ~phase_en),
    .meas_v(meas_v), .meas_err(meas_err), .ph_v(ph_v), .ph_err(ph_err)
  );

  fpd_stream_reg #(.W(ERR_W)) u_fe_out (
    .clk(ref_clk), .rst_n(rrst_n), .in_v(meas_v), .in_d(meas_err),
    .valid(fe_valid), .ready(fe_ready), .data(fe_data)
  );

  fpd_stream_reg #(.W(PH_W)) u_pe_out (
    .clk(ref_clk), .rst_n(rrst_n), .in_v(ph_v), .in_d(ph_err),
    .valid(pe_valid), .ready(pe_ready), .data(pe_data)
  );

  // R1: no result is reported while the reference domain is held in reset
  p_quiet_reset_r1: assert property (@(posedge ref_clk)
    !rrst_n |=> !fe_valid && !pe_valid);
endmodule

// File: tb/wide_freq_phase_det_test.sv
`timescale 1ns/1ps
module wide_freq_phase_det_test;
  logic osc_clk, ref_clk, rst_n, phase_en, fe_ready, pe_ready;
  logic fe_valid, pe_valid;
  logic [7:0] div_n;
  logic signed [8:0] fe_data;
  logic signed [4:0] pe_data;
  real  osc_half = 0.5;
  int   checks = 0;
  int   errors = 0;

  wide_freq_phase_det uut (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n), .div_n(div_n),
    .phase_en(phase_en), .fe_valid(fe_valid), .fe_ready(fe_ready), .fe_data(fe_data),
    .pe_valid(pe_valid), .pe_ready(pe_ready), .pe_data(pe_data)
  );

  initial begin ref_clk = 0; forever #5 ref_clk = ~ref_clk; end
  initial begin osc_clk = 0; #0.3; forever #(osc_half) osc_clk = ~osc_clk; end

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int clamp8(input int v);
    return (v > 8) ? 8 : ((v < -8) ? -8 : v);
  endfunction

  // Collect nmeas frequency results, model the phase sum, check each report.
  task automatic collect(input int nmeas, input int lo, input int hi,
                         input int exp_first, input string tag);
    int seen = 0, strobes = 0, acc_m = 0, guard = 0;
    while (seen < nmeas && guard < nmeas * 3 + 30) begin
      @(negedge ref_clk);
      guard++;
      if (fe_valid) begin
        seen++;
        if (int'(fe_data) < lo || int'(fe_data) > hi)
          check({tag, " freq err in range"}, int'(fe_data), lo);
        else
          check({tag, " freq err in range"}, 1, 1);
        acc_m = clamp8(acc_m + int'(fe_data));
        if (pe_valid) begin
          strobes++;
          check({tag, " R3 report on tenth measurement"}, seen % 10, 0);
          check({tag, " R3 phase equals running sum"}, int'(pe_data), acc_m);
          if (strobes == 1) check({tag, " first phase report"}, int'(pe_data), exp_first);
        end
      end else if (pe_valid) begin
        check({tag, " R3 phase report without measurement"}, 1, 0);
      end
    end
    check({tag, " measurement count"}, seen, nmeas);
    check({tag, " R3 report count"}, strobes, nmeas / 10);
  endtask

  task automatic run_case(input real half, input int n, input int lo, input int hi,
                          input int exp_first, input string tag);
    osc_half = half;
    repeat (6) @(negedge ref_clk);
    div_n = 8'd0;
    @(negedge ref_clk);
    div_n = 8'(n);
    collect(20, lo, hi, exp_first, tag);
  endtask

  task automatic t_reset;
    rst_n = 0; phase_en = 1; fe_ready = 1; pe_ready = 1; div_n = 8'd10;
    repeat (3) @(negedge ref_clk);
    check("R1 fe_valid in reset", int'(fe_valid), 0);
    check("R1 pe_valid in reset", int'(pe_valid), 0);
    rst_n = 1;
    // two sync edges plus three discarded edges: nothing before the sixth negedge
    repeat (5) begin
      @(negedge ref_clk);
      check("R1 no result during warm-up", int'(fe_valid), 0);
    end
    repeat (5) @(negedge ref_clk);
  endtask

  task automatic t_disable;
    int fe_cnt = 0, pe_cnt = 0;
    phase_en = 0;
    osc_half = 0.5;  // 10 edges per period, N=10 -> error 0
    repeat (30) begin
      @(negedge ref_clk);
      if (fe_valid) fe_cnt++;
      if (pe_valid) pe_cnt++;
    end
    check("R6 no phase report while disabled", pe_cnt, 0);
    check("R6 frequency stream continues", int'(fe_cnt > 20), 1);
    phase_en = 1;
    // accumulator was -8 before disabling; a clear makes the first report 0
    collect(10, 0, 0, 0, "R6 re-enable");
  endtask

  task automatic t_backpressure;
    fe_ready = 0;
    repeat (3) @(negedge ref_clk);
    check("R8 valid held while not ready", int'(fe_valid), 1);
    check("R8 held data", int'(fe_data), 0);
    osc_half = 0.25;  // 20 edges per period -> error +10
    repeat (10) @(negedge ref_clk);
    check("R8 valid still held", int'(fe_valid), 1);
    check("R8 newest result replaces held one", int'(fe_data), 10);
    fe_ready = 1;
    osc_half = 0.5;
    repeat (8) @(negedge ref_clk);
  endtask

  task automatic t_nchange;
    div_n = 8'd12;
    @(negedge ref_clk);
    check("R5 change-edge measurement dropped", int'(fe_valid), 0);
    @(negedge ref_clk);
    check("R5 next measurement dropped", int'(fe_valid), 0);
    @(negedge ref_clk);
    check("R5 first result after change valid", int'(fe_valid), 1);
    check("R5 first result uses new ratio", int'(fe_data), -2);
  endtask

  initial begin
    t_reset();
    run_case(0.5,  10,  0,  0,  0, "R2 R7 locked");   // 10 edges, exact count
    run_case(0.25, 16,  4,  4,  8, "R4 positive sat"); // 20 edges, +4 each
    run_case(0.4,  12,  0,  1,  5, "R3 R5 integrate after clear"); // 12.5 edges
    run_case(1.0,  10, -5, -5, -8, "R4 negative sat"); // 5 edges, -5 each
    div_n = 8'd10;
    t_disable();
    t_backpressure();
    t_nchange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule